// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block is a synchronous model of the control logic inside a word-wide NOR-style flash device. The host reaches it through a chip-select, read-strobe and write-strobe bus, all sampled on the system clock `clk`. The controller turns multi-write unlock sequences into word program, sector erase, chip erase and boot-region lockout operations. It holds a small parameterised storage array, times every program and erase with an internal down-counter, and reports progress both on a busy pin and through a status word that the bus returns while an operation is running.

The array has three erase regions. Sector 0 covers words `[0, PARAM_WORDS)` and sector 1 covers `[PARAM_WORDS, 2*PARAM_WORDS)`. Sector 2 covers every remaining word, and its top `BOOT_WORDS` words form the boot region. Programming can only clear bits, so a word must be erased back to all ones before it can take new data freely. A warm reset pin aborts whatever is running. A separate power-on reset is the only way to clear the boot lockout, and an override input stands in for a high-voltage reset level that lifts the lockout.

The bus is a strobe bus whose timing is fixed, so it has no valid/ready handshake. The host must leave a write sequence alone until the busy pin drops, because the controller has no back-pressure. All bus inputs are taken to be synchronous to `clk`.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: `dq_oe` is high only while `ce_n` and `oe_n` are low, `we_n` is high and `rst_n` is high. When idle, `dq_out` then carries the array word at `addr`. Otherwise `dq_oe` is low and `dq_out` is zero.
- R2: A bus write is the interval in which `ce_n` and `we_n` are both low with `oe_n` high. Its address is taken in the first clock of that interval. Its data is the last value seen before the interval ends.
- R3: Command codes are matched on `dq_in[7:0]` only. Bits 15:8 of a command write have no effect.
- R4: A program is four writes: 0xAA at the first unlock address (0x555 truncated to `AW` bits), 0x55 at the second (0x2AA truncated), 0xA0 at the first, then the target address and data. Command writes leave the array untouched.
- R5: A program stores the old word AND the new data, so it can only clear bits.
- R6: A write that does not match the next expected word of a sequence returns the decoder to read mode. That write is discarded.
- R7: A sector erase is 0xAA/0x55/0x80/0xAA/0x55 at the unlock addresses, then 0x30 at any address in the sector. It sets every word of that sector to all ones and leaves the other sectors unchanged.
- R8: A chip erase ends its sequence with 0x10 at the first unlock address instead. It sets every unprotected word to all ones.
- R9: `busy` stays high for exactly `PROG_CYC` cycles for a program and `ERASE_CYC` cycles for an erase. Bus writes made while it is high are ignored.
- R10: While `busy` is high, a read returns a status word. Bit 7 is the complement of bit 7 of the target data (0 for an erase). Bit 6 inverts on each new read access. All other bits are 0.
- R11: 0xAA/0x55/0x40 at the unlock addresses sets the lockout. While it is set and `hv_override` is low, a program to the boot region and an erase of sector 2 are refused with no busy period, and a chip erase spares the boot region. With `hv_override` high the lockout is lifted.
- R12: While `rst_n` is low, `busy` and `dq_oe` are low and the running operation is dropped without touching the array. The lockout survives.
- R13: `por_n` low clears the lockout and sets every array word to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus inputs are sampled on its rising edge |
| por_n | input | 1 | Power-on reset, active low; clears array and lockout |
| rst_n | input | 1 | Warm reset pin, active low; aborts operations |
| hv_override | input | 1 | Lifts the boot lockout while high |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Word address |
| dq_in | input | DW | Write data from the host |
| dq_out | output | DW | Read data or status word |
| dq_oe | output | 1 | Data bus drive enable; low means floated |
| busy | output | 1 | An internally timed operation is in progress |

## Verification
The two functions that can overlap in time are a running erase and new bus activity: a read that must yield status instead of array data, and a fresh unlock-and-program sequence. The bench starts a sector erase and issues two reads and a complete program sequence while `busy` is still high. It judges the status bits of both reads against each other and confirms afterwards that the programmed word is still erased. A warm reset arriving in the middle of an erase is the second overlap. It is judged by the word the erase would have cleared, which must keep its old value.

// File: rtl/flash_pkg.sv
package flash_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_PROG,
    OP_SECT,
    OP_CHIP,
    OP_LOCK
  } op_e;

  typedef enum logic [2:0] {
    SQ_READ,
    SQ_UNLK1,
    SQ_UNLK2,
    SQ_PGM,
    SQ_ERA1,
    SQ_ERA2,
    SQ_ERA3
  } seq_e;

  localparam logic [7:0] CODE_KEY1  = 8'hAA;
  localparam logic [7:0] CODE_KEY2  = 8'h55;
  localparam logic [7:0] CODE_PROG  = 8'hA0;
  localparam logic [7:0] CODE_ERPRE = 8'h80;
  localparam logic [7:0] CODE_LOCK  = 8'h40;
  localparam logic [7:0] CODE_CHIP  = 8'h10;
  localparam logic [7:0] CODE_SECT  = 8'h30;

endpackage

// File: rtl/flash_bus_capture.sv
module flash_bus_capture #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  logic          wr_act;
  logic          act_q;
  logic [AW-1:0] a_lat;
  logic [DW-1:0] d_lat;

  // write interval: both selects low, read strobe high
  assign wr_act = !ce_n && !we_n && oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      a_lat  <= '0;
      d_lat  <= '0;
      wr_stb <= 1'b0;
    end else begin
      act_q  <= wr_act;
      wr_stb <= act_q && !wr_act;
      if (wr_act && !act_q) a_lat <= addr;   // address at the start
      if (wr_act)           d_lat <= dq_in;  // data tracks until the end
    end
  end

  assign wr_addr = a_lat;
  assign wr_data = d_lat;

endmodule

// File: rtl/flash_seq_decode.sv
module flash_seq_decode
  import flash_pkg::*;
#(
  parameter int AW      = 6,
  parameter int DW      = 16,
  parameter int UNLK_A1 = 'h555,
  parameter int UNLK_A2 = 'h2AA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          cmd_v,
  output op_e           cmd_op,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data
);

  localparam logic [AW-1:0] KEY_A1 = AW'(UNLK_A1);
  localparam logic [AW-1:0] KEY_A2 = AW'(UNLK_A2);

  seq_e        st_q;
  logic [7:0]  code;
  logic        at_a1;
  logic        at_a2;

  assign code  = wr_data[7:0];
  assign at_a1 = (wr_addr == KEY_A1);
  assign at_a2 = (wr_addr == KEY_A2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SQ_READ;
      cmd_v    <= 1'b0;
      cmd_op   <= OP_NONE;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      cmd_v <= 1'b0;
      if (busy) begin
        st_q <= SQ_READ;
      end else if (wr_stb) begin
        st_q <= SQ_READ;
        case (st_q)
          SQ_READ:  if (at_a1 && code == CODE_KEY1) st_q <= SQ_UNLK1;
          SQ_UNLK1: if (at_a2 && code == CODE_KEY2) st_q <= SQ_UNLK2;
          SQ_UNLK2: begin
            if (at_a1 && code == CODE_PROG)  st_q <= SQ_PGM;
            if (at_a1 && code == CODE_ERPRE) st_q <= SQ_ERA1;
            if (at_a1 && code == CODE_LOCK) begin
              cmd_v  <= 1'b1;
              cmd_op <= OP_LOCK;
            end
          end
          SQ_PGM: begin
            cmd_v    <= 1'b1;
            cmd_op   <= OP_PROG;
            cmd_addr <= wr_addr;
            cmd_data <= wr_data;
          end
          SQ_ERA1: if (at_a1 && code == CODE_KEY1) st_q <= SQ_ERA2;
          SQ_ERA2: if (at_a2 && code == CODE_KEY2) st_q <= SQ_ERA3;
          SQ_ERA3: begin
            if (at_a1 && code == CODE_CHIP) begin
              cmd_v  <= 1'b1;
              cmd_op <= OP_CHIP;
            end else if (code == CODE_SECT) begin
              cmd_v    <= 1'b1;
              cmd_op   <= OP_SECT;
              cmd_addr <= wr_addr;
            end
          end
          default: st_q <= SQ_READ;
        endcase
      end
    end
  end

endmodule

// File: rtl/flash_array_ctrl.sv
module flash_array_ctrl
  import flash_pkg::*;
#(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int PARAM_WORDS = 8,
  parameter int BOOT_WORDS  = 8,
  parameter int PROG_CYC    = 6,
  parameter int ERASE_CYC   = 24
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          sys_rst_n,
  input  logic          hv_override,
  input  logic          cmd_v,
  input  op_e           cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          rd_act,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          locked
);

  localparam int DEPTH = 1 << AW;
  localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW    = $clog2(MAXC + 1);
  localparam logic [AW:0] SEC1_BASE = (AW+1)'(PARAM_WORDS);
  localparam logic [AW:0] SEC2_BASE = (AW+1)'(2 * PARAM_WORDS);
  localparam logic [AW:0] BOOT_BASE = (AW+1)'(DEPTH - BOOT_WORDS);

  function automatic logic [1:0] sector_of(input logic [AW-1:0] a);
    if ({1'b0, a} < SEC1_BASE)      return 2'd0;
    else if ({1'b0, a} < SEC2_BASE) return 2'd1;
    else                            return 2'd2;
  endfunction

  function automatic logic in_boot(input logic [AW-1:0] a);
    return ({1'b0, a} >= BOOT_BASE);
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic          busy_q;
  logic [CW-1:0] cnt_q;
  op_e           op_q;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;
  logic          spare_boot_q;
  logic          lock_q;
  logic          rd_q;
  logic          tog_q;
  logic          allow;
  logic          start;
  logic          done;

  assign allow = !lock_q || hv_override;

  always_comb begin
    start = 1'b0;
    if (cmd_v && !busy_q) begin
      case (cmd_op)
        OP_PROG: start = allow || !in_boot(cmd_addr);
        OP_SECT: start = allow || (sector_of(cmd_addr) != 2'd2);
        OP_CHIP: start = 1'b1;
        default: start = 1'b0;
      endcase
    end
  end

  assign done = busy_q && (cnt_q == CW'(1));

  // operation timer
  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      busy_q       <= 1'b0;
      cnt_q        <= '0;
      op_q         <= OP_NONE;
      a_q          <= '0;
      d_q          <= '0;
      spare_boot_q <= 1'b0;
    end else if (start) begin
      busy_q       <= 1'b1;
      cnt_q        <= (cmd_op == OP_PROG) ? CW'(PROG_CYC) : CW'(ERASE_CYC);
      op_q         <= cmd_op;
      a_q          <= cmd_addr;
      d_q          <= (cmd_op == OP_PROG) ? cmd_data : '1;
      spare_boot_q <= !allow;
    end else if (busy_q) begin
      cnt_q <= cnt_q - CW'(1);
      if (done) busy_q <= 1'b0;
    end
  end

  // storage array, written only when an operation completes
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (done) begin
      if (op_q == OP_PROG) begin
        mem[a_q] <= mem[a_q] & d_q;
      end else begin
        for (int i = 0; i < DEPTH; i++) begin
          if ((op_q == OP_CHIP || sector_of(AW'(i)) == sector_of(a_q)) &&
              !(spare_boot_q && in_boot(AW'(i))))
            mem[i] <= '1;
        end
      end
    end
  end

  // lockout survives the warm reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                                      lock_q <= 1'b0;
    else if (cmd_v && cmd_op == OP_LOCK && !busy_q)  lock_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      rd_q  <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      rd_q <= rd_act;
      if (rd_act && !rd_q && busy_q) tog_q <= !tog_q;
    end
  end

  always_comb begin
    if (busy_q) begin
      rd_data    = '0;
      rd_data[7] = !d_q[7];
      rd_data[6] = tog_q;
    end else begin
      rd_data = mem[rd_addr];
    end
  end

  assign busy   = busy_q;
  assign locked = lock_q;

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_pkg::*;
#(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int PARAM_WORDS = 8,
  parameter int BOOT_WORDS  = 8,
  parameter int PROG_CYC    = 6,
  parameter int ERASE_CYC   = 24,
  parameter int UNLK_A1     = 'h555,
  parameter int UNLK_A2     = 'h2AA
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          hv_override,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          busy
);

  logic          sys_rst_n;
  logic          rd_act;
  logic          wr_stb;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          cmd_v;
  op_e           cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic [DW-1:0] rd_data;
  logic          locked;

  assign sys_rst_n = por_n && rst_n;
  assign rd_act    = !ce_n && !oe_n && we_n && rst_n;

  flash_bus_capture #(.AW(AW), .DW(DW)) i_cap (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .we_n    (we_n),
    .addr    (addr),
    .dq_in   (dq_in),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  flash_seq_decode #(.AW(AW), .DW(DW), .UNLK_A1(UNLK_A1), .UNLK_A2(UNLK_A2)) i_dec (
    .clk      (clk),
    .rst_n    (sys_rst_n),
    .busy     (busy),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cmd_v    (cmd_v),
    .cmd_op   (cmd_op),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data)
  );

  flash_array_ctrl #(
    .AW(AW), .DW(DW), .PARAM_WORDS(PARAM_WORDS), .BOOT_WORDS(BOOT_WORDS),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) i_arr (
    .clk         (clk),
    .por_n       (por_n),
    .sys_rst_n   (sys_rst_n),
    .hv_override (hv_override),
    .cmd_v       (cmd_v),
    .cmd_op      (cmd_op),
    .cmd_addr    (cmd_addr),
    .cmd_data    (cmd_data),
    .rd_act      (rd_act),
    .rd_addr     (addr),
    .rd_data     (rd_data),
    .busy        (busy),
    .locked      (locked)
  );

  assign dq_oe  = rd_act;
  assign dq_out = rd_act ? rd_data : '0;

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          por_n,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe,
  input logic          busy,
  input logic          locked
);

  AST_FLOAT_IDLE: assert property (@(posedge clk) disable iff (!por_n)
    (ce_n || oe_n || !rst_n) |-> !dq_oe);  // R1

  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!por_n)
    !we_n |-> !dq_oe);  // R1

  AST_BUSY_MIN_LEN: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(busy) |=> busy);  // R9

  AST_STATUS_FORMAT: assert property (@(posedge clk) disable iff (!por_n)
    (busy && dq_oe) |-> ((dq_out & ~(DW'(8'hC0))) == '0));  // R10

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    $past(locked) |-> locked);  // R11

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |-> (!busy && !dq_oe));  // R12

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.DW(DW)) i_chk (.*);

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int PROG_CYC = 12;
  localparam int ERASE_CYC = 60;
  localparam logic [AW-1:0] K1 = 6'h15;  // 0x555 truncated
  localparam logic [AW-1:0] K2 = 6'h2A;  // 0x2AA truncated

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic          rst_n = 1'b0;
  logic          hv_override = 1'b0;
  logic          ce_n = 1'b1;
  logic          oe_n = 1'b1;
  logic          we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;
  logic          busy;

  int nchk = 0;
  int nfail = 0;

  flash_cmd_ctrl #(
    .AW(AW), .DW(DW), .PARAM_WORDS(8), .BOOT_WORDS(8),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) i_flash_cmd_ctrl (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .hv_override(hv_override),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // kind: 0 write, 1 wait until idle, 2 read and compare
  typedef struct packed {
    logic [1:0]    kind;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VT [NV] = '{
    '{2'd0, 6'h15, 16'h00AA, 4'd4}, '{2'd0, 6'h2A, 16'h0055, 4'd4},
    '{2'd0, 6'h15, 16'h00A0, 4'd4}, '{2'd0, 6'h03, 16'hF0F3, 4'd4},
    '{2'd1, 6'h00, 16'h0000, 4'd4}, '{2'd2, 6'h03, 16'hF0F3, 4'd4},   // R4 program
    '{2'd2, 6'h15, 16'hFFFF, 4'd4},                                    // R4 cmd addr untouched
    '{2'd0, 6'h15, 16'h00AA, 4'd5}, '{2'd0, 6'h2A, 16'h0055, 4'd5},
    '{2'd0, 6'h15, 16'h00A0, 4'd5}, '{2'd0, 6'h03, 16'h0F0F, 4'd5},
    '{2'd1, 6'h00, 16'h0000, 4'd5}, '{2'd2, 6'h03, 16'h0003, 4'd5},   // R5 AND
    '{2'd0, 6'h15, 16'h12AA, 4'd3}, '{2'd0, 6'h2A, 16'hFF55, 4'd3},
    '{2'd0, 6'h15, 16'h77A0, 4'd3}, '{2'd0, 6'h20, 16'h1234, 4'd3},
    '{2'd1, 6'h00, 16'h0000, 4'd3}, '{2'd2, 6'h20, 16'h1234, 4'd3},   // R3 upper byte
    '{2'd0, 6'h15, 16'h00AA, 4'd6}, '{2'd0, 6'h2A, 16'h0056, 4'd6},
    '{2'd0, 6'h15, 16'h00A0, 4'd6}, '{2'd0, 6'h21, 16'h0000, 4'd6},
    '{2'd1, 6'h00, 16'h0000, 4'd6}, '{2'd2, 6'h21, 16'hFFFF, 4'd6},   // R6 bad word
    '{2'd0, 6'h15, 16'h00AA, 4'd7}, '{2'd0, 6'h2A, 16'h0055, 4'd7},
    '{2'd0, 6'h15, 16'h0080, 4'd7}, '{2'd0, 6'h15, 16'h00AA, 4'd7},
    '{2'd0, 6'h2A, 16'h0055, 4'd7}, '{2'd0, 6'h02, 16'h0030, 4'd7},
    '{2'd1, 6'h00, 16'h0000, 4'd7},
    '{2'd2, 6'h03, 16'hFFFF, 4'd7}, '{2'd2, 6'h20, 16'h1234, 4'd7}    // R7 sector 0 only
  };

  task automatic check(input int req, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; dq_in = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_write_shift(input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                                 input logic [DW-1:0] d0, input logic [DW-1:0] d1);
    @(negedge clk);
    addr = a0; dq_in = d0; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    addr = a1; dq_in = d1;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] v,
                          output logic oe);
    @(negedge clk);
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    repeat (2) @(negedge clk);
    v = dq_out; oe = dq_oe;
    oe_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    int guard = 0;
    repeat (4) @(negedge clk);
    while (busy && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic read_check(input int req, input logic [AW-1:0] a,
                            input logic [DW-1:0] exp);
    logic [DW-1:0] v;
    logic oe;
    bus_read(a, v, oe);
    check(req, $sformatf("read %h", a), v, exp);
  endtask

  task automatic do_prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_write(K1, 16'h00AA); bus_write(K2, 16'h0055);
    bus_write(K1, 16'h00A0); bus_write(a, d);
  endtask

  task automatic do_erase(input logic [AW-1:0] a, input logic [7:0] code);
    bus_write(K1, 16'h00AA); bus_write(K2, 16'h0055); bus_write(K1, 16'h0080);
    bus_write(K1, 16'h00AA); bus_write(K2, 16'h0055); bus_write(a, {8'h00, code});
  endtask

  task automatic expect_no_busy(input int req, input string what);
    logic seen = 1'b0;
    repeat (6) begin
      @(negedge clk);
      if (busy) seen = 1'b1;
    end
    check(req, what, {15'd0, seen}, 16'd0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [DW-1:0] v1, v2;
    logic oe;
    int cnt;

    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R13 / R1 reset state
    check(13, "busy after reset", {15'd0, busy}, 16'd0);
    check(1, "oe idle after reset", {15'd0, dq_oe}, 16'd0);
    read_check(13, 6'h00, 16'hFFFF);
    read_check(13, 6'h3F, 16'hFFFF);
    // R1: output enable held but chip not selected
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
    @(negedge clk);
    check(1, "floated with ce_n high", {15'd0, dq_oe}, 16'd0);
    check(1, "zero data when floated", dq_out, 16'h0000);
    oe_n = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      case (VT[i].kind)
        2'd0: bus_write(VT[i].a, VT[i].d);
        2'd1: wait_idle();
        default: begin
          bus_read(VT[i].a, v1, oe);
          check(int'(VT[i].req), $sformatf("vector %0d", i), v1, VT[i].d);
          check(1, "drive during read", {15'd0, oe}, 16'd1);
        end
      endcase
    end

    // R2: address from start of write, data from its end
    bus_write(K1, 16'h00AA); bus_write(K2, 16'h0055); bus_write(K1, 16'h00A0);
    bus_write_shift(6'h0A, 6'h0B, 16'h0000, 16'h00FF);
    wait_idle();
    read_check(2, 6'h0A, 16'h00FF);
    read_check(2, 6'h0B, 16'hFFFF);

    // R9: program busy length
    do_prog(6'h0C, 16'h0F00);
    cnt = 0;
    while (!busy && cnt < 8) begin @(negedge clk); cnt++; end
    cnt = 0;
    while (busy && cnt < 200) begin @(negedge clk); cnt++; end
    check(9, "program busy cycles", 16'(cnt), 16'(PROG_CYC));

    // R9/R10: erase of sector 1 overlapped with reads and writes
    do_erase(6'h09, 8'h30);
    @(negedge clk);
    check(9, "busy after erase start", {15'd0, busy}, 16'd1);
    bus_read(6'h09, v1, oe);
    bus_read(6'h09, v2, oe);
    check(10, "status bit7 on erase", {15'd0, v1[7]}, 16'd0);
    check(10, "status bit6 inverts", {15'd0, v1[6] ^ v2[6]}, 16'd1);
    check(10, "status other bits", v2 & 16'hFF3F, 16'h0000);
    do_prog(6'h22, 16'h0000);  // ignored while busy (R9)
    wait_idle();
    read_check(9, 6'h22, 16'hFFFF);
    read_check(7, 6'h0A, 16'hFFFF);
    read_check(7, 6'h0C, 16'hFFFF);

    // R10: program status bit7 is complement of data bit7
    do_prog(6'h01, 16'h0080);
    @(negedge clk);
    bus_read(6'h01, v1, oe);
    check(10, "status bit7 on program", {15'd0, v1[7]}, 16'd0);
    wait_idle();

    // R11 lockout
    do_prog(6'h3A, 16'h1234);
    wait_idle();
    bus_write(K1, 16'h00AA); bus_write(K2, 16'h0055); bus_write(K1, 16'h0040);
    do_prog(6'h3A, 16'h0000);
    expect_no_busy(11, "boot program refused");
    read_check(11, 6'h3A, 16'h1234);
    do_erase(6'h30, 8'h30);
    expect_no_busy(11, "sector 2 erase refused");
    read_check(11, 6'h20, 16'h1234);
    do_erase(K1, 8'h10);  // R8 chip erase
    wait_idle();
    read_check(11, 6'h3A, 16'h1234);
    read_check(8, 6'h20, 16'hFFFF);
    read_check(8, 6'h03, 16'hFFFF);
    hv_override = 1'b1;
    do_prog(6'h3A, 16'h0000);
    wait_idle();
    read_check(11, 6'h3A, 16'h0000);
    hv_override = 1'b0;

    // R12 abort by warm reset
    do_prog(6'h05, 16'h0000);
    wait_idle();
    do_erase(6'h05, 8'h30);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    check(12, "busy during reset", {15'd0, busy}, 16'd0);
    check(12, "floated during reset", {15'd0, dq_oe}, 16'd0);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    repeat (ERASE_CYC + 5) @(negedge clk);
    read_check(12, 6'h05, 16'h0000);
    do_prog(6'h3B, 16'h0000);
    expect_no_busy(12, "lockout kept over warm reset");

    // R13 power-on reset clears lockout and array
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    @(negedge clk);
    read_check(13, 6'h05, 16'hFFFF);
    do_prog(6'h3B, 16'h0000);
    wait_idle();
    read_check(13, 6'h3B, 16'h0000);

    finish_run();
  end

endmodule